// File: doc/BRIEF.md
# I2C Register and Stream Read Target

This block is a read-only target on a two-wire serial bus. SCL and SDA arrive as open-drain inputs. The block drives SDA only by pulling it low. Both lines are sampled in the system clock domain. START, repeated START and STOP are taken from SDA edges that occur while SCL is high.

One 8-bit pointer selects what the block sends. For addresses 0x00 to 0xFE, the byte comes from an external register read port: the block presents the pointer as an address, and the register file answers combinationally. Address 0xFF is not a register. It is a window onto an external byte FIFO, so each byte read there takes the next stream entry. If the FIFO is empty, the block sends 0xFF as filler.

The pointer starts at 0xFF, so a plain read drains the stream by default. A write-addressed transfer carrying one byte moves the pointer. A repeated START with a read address then returns data from that location. Each byte sent advances the pointer by one, and it stops advancing at 0xFF. A read that is not preceded by a pointer write continues from where the last access left off.

Top module: `i2c_regstream_target`

## Requirements
- R1: The block acknowledges (drives SDA low during the ninth clock) only a first byte whose upper seven bits equal `DEV_ADDR`. Bit 0 of that byte is 0 for write and 1 for read. After any other first byte it leaves SDA released until the next START or STOP.
- R2: After a matched write address, the block acknowledges the next byte, and that byte becomes the pointer shown on `reg_addr`.
- R3: A repeated START followed by a matched read address returns `reg_rdata` for the pointer value, MSB first.
- R4: In the read phase, the controller's acknowledge (SDA low) requests another byte. After a not-acknowledge (SDA high), the block releases SDA and sends nothing more until a START or STOP.
- R5: Each byte sent (acknowledged or not) advances the pointer by one. At 0xFF the pointer holds its value.
- R6: After reset the pointer is 0xFF, and a read with no pointer write returns stream bytes in FIFO order.
- R7: A read without a pointer write continues at the address after the last byte sent.
- R8: A byte sent at 0xFF while `strm_valid` is low is 0xFF, and the FIFO is not popped.
- R9: `strm_pop` pulses for one cycle exactly once per stream byte. The pulse comes in the ninth clock of that byte. A transfer that only writes the pointer pops nothing.
- R10: A START in any state, including partway through a byte, abandons the current byte and begins a new address phase. A STOP returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 8 | Current pointer, register read address |
| reg_rdata | input | 8 | Register content at `reg_addr` |
| strm_valid | input | 1 | Stream FIFO holds a byte |
| strm_data | input | 8 | Stream FIFO head byte |
| strm_pop | output | 1 | One-cycle pop of the stream FIFO head |

## Verification
The hardest case to reach is a single read that crosses from register space into the stream and then runs past the end of the FIFO. It must send two register bytes, then the remaining stream entries, then filler, with no extra pop. The bench reaches this by preloading a short FIFO and partly draining it first. It then sets the pointer to 0xFD and reads enough bytes to pass both boundaries, checking every byte against a model of pointer and FIFO head. An abandoned pointer byte, cut off by a repeated START after three bits, shows that a partial byte never loads the pointer.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    localparam int BYTE_W  = 8;
    localparam int BIT_CW  = 4;
    localparam logic [BYTE_W-1:0] FILL_BYTE = '1;
    localparam logic [BIT_CW-1:0] BITS_PER_BYTE = BIT_CW'(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_PTR,
        ST_PACK,
        ST_TX,
        ST_TACK,
        ST_WAIT
    } tgt_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              from_stream;
    } tx_src_t;

    function automatic logic is_stream_addr(input logic [BYTE_W-1:0] a);
        return a == '1;
    endfunction

endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync
    import i2c_rs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_rs_ptr.sv
module i2c_rs_ptr
    import i2c_rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              adv,
    output logic [BYTE_W-1:0] ptr
);

    localparam logic [BYTE_W-1:0] PTR_MAX = '1;

    logic [BYTE_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= PTR_MAX;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (adv && ptr_q != PTR_MAX) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;

    p_saturate_r5: assert property (@(posedge clk) disable iff (rst)
        (ptr_q == PTR_MAX && !load) |=> ptr_q == PTR_MAX);

    p_advance_r5: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && ptr_q != PTR_MAX) |=> ptr_q == $past(ptr_q) + 1'b1);

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> ptr_q == $past(load_val));

endmodule

// File: rtl/i2c_rs_src.sv
module i2c_rs_src
    import i2c_rs_pkg::*;
(
    input  logic [BYTE_W-1:0] ptr,
    input  logic [BYTE_W-1:0] reg_rdata,
    input  logic              strm_valid,
    input  logic [BYTE_W-1:0] strm_data,
    output tx_src_t           src
);

    always_comb begin
        if (!is_stream_addr(ptr)) begin
            src.data        = reg_rdata;
            src.from_stream = 1'b0;
        end else if (strm_valid) begin
            src.data        = strm_data;
            src.from_stream = 1'b1;
        end else begin
            src.data        = FILL_BYTE;
            src.from_stream = 1'b0;
        end
    end

endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h42
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  tx_src_t           src,
    output logic              sda_low,
    output logic              ptr_load,
    output logic [BYTE_W-1:0] ptr_val,
    output logic              ptr_adv,
    output logic              pop
);

    tgt_state_e        st_q;
    logic [BIT_CW-1:0] cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic              drive_q;
    logic              rw_q;
    logic              acked_q;
    logic              tx_strm_q;
    logic              quiet;
    logic              byte_in;

    assign quiet   = ~ev.start & ~ev.stop;
    assign byte_in = (cnt_q == BITS_PER_BYTE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            sh_q      <= '0;
            drive_q   <= 1'b0;
            rw_q      <= 1'b0;
            acked_q   <= 1'b0;
            tx_strm_q <= 1'b0;
        end else if (ev.start) begin
            st_q    <= ST_ADDR;
            cnt_q   <= '0;
            drive_q <= 1'b0;
        end else if (ev.stop) begin
            st_q    <= ST_IDLE;
            drive_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_ADDR, ST_PTR: begin
                    if (ev.scl_rise && !byte_in) begin
                        sh_q  <= {sh_q[BYTE_W-2:0], ev.sda};
                        cnt_q <= cnt_q + 1'b1;
                    end else if (ev.scl_fall && byte_in) begin
                        if (st_q == ST_PTR) begin
                            st_q    <= ST_PACK;
                            drive_q <= 1'b1;
                        end else if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                            st_q    <= ST_AACK;
                            rw_q    <= sh_q[0];
                            drive_q <= 1'b1;
                        end else begin
                            st_q    <= ST_WAIT;
                            drive_q <= 1'b0;
                        end
                    end
                end
                ST_AACK: begin
                    if (ev.scl_fall) begin
                        cnt_q <= '0;
                        if (rw_q) begin
                            st_q      <= ST_TX;
                            sh_q      <= src.data;
                            tx_strm_q <= src.from_stream;
                            drive_q   <= ~src.data[BYTE_W-1];
                        end else begin
                            st_q    <= ST_PTR;
                            drive_q <= 1'b0;
                        end
                    end
                end
                ST_PACK: begin
                    if (ev.scl_fall) begin
                        st_q    <= ST_WAIT;
                        drive_q <= 1'b0;
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (cnt_q == BITS_PER_BYTE - 1'b1) begin
                            st_q    <= ST_TACK;
                            drive_q <= 1'b0;
                        end else begin
                            sh_q    <= {sh_q[BYTE_W-2:0], 1'b0};
                            drive_q <= ~sh_q[BYTE_W-2];
                            cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_TACK: begin
                    if (ev.scl_rise) begin
                        acked_q <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        cnt_q <= '0;
                        if (acked_q) begin
                            st_q      <= ST_TX;
                            sh_q      <= src.data;
                            tx_strm_q <= src.from_stream;
                            drive_q   <= ~src.data[BYTE_W-1];
                        end else begin
                            st_q    <= ST_WAIT;
                            drive_q <= 1'b0;
                        end
                    end
                end
                default: begin
                    drive_q <= 1'b0;
                end
            endcase
        end
    end

    assign sda_low  = drive_q;
    assign ptr_load = quiet && st_q == ST_PTR && ev.scl_fall && byte_in;
    assign ptr_val  = sh_q;
    assign ptr_adv  = quiet && st_q == ST_TACK && ev.scl_rise;
    assign pop      = ptr_adv && tx_strm_q;

    p_released_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE || st_q == ST_WAIT) |-> !drive_q);

    p_start_restarts_r10: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (st_q == ST_ADDR && cnt_q == '0));

    p_stop_idles_r10: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !ev.start) |=> st_q == ST_IDLE);

    p_ack_after_match_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_AACK) |-> drive_q);

endmodule

// File: rtl/i2c_regstream_target.sv
module i2c_regstream_target
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h42,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_low,
    output logic [7:0] reg_addr,
    input  logic [7:0] reg_rdata,
    input  logic       strm_valid,
    input  logic [7:0] strm_data,
    output logic       strm_pop
);

    bus_ev_t           ev;
    tx_src_t           src;
    logic              ptr_load;
    logic [BYTE_W-1:0] ptr_val;
    logic              ptr_adv;
    logic [BYTE_W-1:0] ptr;

    i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_rs_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (ptr_val),
        .adv      (ptr_adv),
        .ptr      (ptr)
    );

    i2c_rs_src u_src (
        .ptr        (ptr),
        .reg_rdata  (reg_rdata),
        .strm_valid (strm_valid),
        .strm_data  (strm_data),
        .src        (src)
    );

    i2c_rs_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .src      (src),
        .sda_low  (sda_drive_low),
        .ptr_load (ptr_load),
        .ptr_val  (ptr_val),
        .ptr_adv  (ptr_adv),
        .pop      (strm_pop)
    );

    assign reg_addr = ptr;

    p_pop_needs_data_r8: assert property (@(posedge clk) disable iff (rst)
        strm_pop |-> strm_valid);

    p_pop_single_r9: assert property (@(posedge clk) disable iff (rst)
        strm_pop |=> !strm_pop);

    p_pop_at_stream_r9: assert property (@(posedge clk) disable iff (rst)
        strm_pop |-> reg_addr == 8'hFF);

endmodule

// File: tb/i2c_regstream_target_tb.sv
module i2c_regstream_target_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 6;
    localparam int         WDOG       = 190000;
    localparam logic [6:0] DEV        = 7'h42;
    localparam int         FDEPTH     = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tb_scl = 1'b1;
    logic       tb_sda_low = 1'b0;
    logic       sda_line;
    logic       sda_drive_low;
    logic [7:0] reg_addr;
    logic [7:0] reg_rdata;
    logic       strm_valid;
    logic [7:0] strm_data;
    logic       strm_pop;

    logic [7:0] fmem [FDEPTH];
    int         fhead = 0;
    int         fcount = 0;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    logic [7:0] mptr;
    int         mhead;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line   = !(tb_sda_low || sda_drive_low);
    assign reg_rdata  = 8'((reg_addr * 7) + 3);
    assign strm_valid = fhead < fcount;
    assign strm_data  = fmem[fhead[3:0]];

    always @(posedge clk) begin
        if (strm_pop) fhead <= fhead + 1;
    end

    i2c_regstream_target #(.DEV_ADDR(DEV)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (tb_scl),
        .sda_i         (sda_line),
        .sda_drive_low (sda_drive_low),
        .reg_addr      (reg_addr),
        .reg_rdata     (reg_rdata),
        .strm_valid    (strm_valid),
        .strm_data     (strm_data),
        .strm_pop      (strm_pop)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        tb_sda_low = !b;
        tick(Q); tb_scl = 1'b1; tick(2*Q); tb_scl = 1'b0; tick(Q);
    endtask

    task automatic bit_in(output logic b);
        tb_sda_low = 1'b0;
        tick(Q); tb_scl = 1'b1; tick(Q); b = sda_line; tick(Q); tb_scl = 1'b0; tick(Q);
    endtask

    task automatic send_start();
        if (!tb_scl) begin
            tb_sda_low = 1'b0; tick(Q); tb_scl = 1'b1; tick(Q);
        end
        tb_sda_low = 1'b1; tick(Q); tb_scl = 1'b0; tick(Q);
    endtask

    task automatic send_stop();
        tb_sda_low = 1'b1; tick(Q); tb_scl = 1'b1; tick(Q); tb_sda_low = 1'b0; tick(2*Q);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        ack = !a;
    endtask

    task automatic read_byte(input logic more, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(!more);
    endtask

    function automatic logic [7:0] model_next();
        logic [7:0] e;
        if (mptr == 8'hFF) begin
            if (mhead < fcount) begin
                e = fmem[mhead[3:0]];
                mhead++;
            end else begin
                e = 8'hFF;
            end
        end else begin
            e = 8'((mptr * 7) + 3);
        end
        if (mptr != 8'hFF) mptr = mptr + 8'd1;
        return e;
    endfunction

    task automatic set_ptr(input logic [7:0] p, input logic stop_after);
        logic a;
        send_start();
        write_byte({DEV, 1'b0}, a);
        chk("R1 write address ack", a, 1);
        write_byte(p, a);
        chk("R2 pointer byte ack", a, 1);
        chk("R2 pointer loaded", reg_addr, p);
        mptr = p;
        if (stop_after) send_stop();
    endtask

    task automatic read_n(input int n, input string req);
        logic a;
        logic [7:0] v;
        logic [7:0] e;
        send_start();
        write_byte({DEV, 1'b1}, a);
        chk("R1 read address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            read_byte(k < n - 1, v);
            e = model_next();
            chk(req, v, e);
        end
        tick(Q);
        chk("R4 SDA released after nack", sda_drive_low, 0);
        send_stop();
        chk("R9 pop count", fhead, mhead);
        chk("R5 pointer after read", reg_addr, mptr);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", WDOG, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        logic b;
        logic [7:0] v;
        for (int i = 0; i < FDEPTH; i++) fmem[i] = 8'(8'h80 + i * 3);
        fcount = 5;
        mhead  = 0;
        mptr   = 8'hFF;
        tick(5);
        rst = 1'b0;
        tick(4);

        chk("R6 reset pointer", reg_addr, 8'hFF);
        chk("R4 reset SDA released", sda_drive_low, 0);
        chk("R9 reset no pop", strm_pop, 0);

        // R6: plain read with no pointer write drains stream in order
        read_n(3, "R6 stream byte");

        // R1: mismatched write address ignored
        send_start();
        write_byte({7'h13, 1'b0}, a);
        chk("R1 mismatch not acked", a, 0);
        write_byte(8'h05, a);
        chk("R1 mismatch data not acked", a, 0);
        send_stop();
        chk("R1 mismatch leaves pointer", reg_addr, 8'hFF);

        // R1: mismatched read address never drives SDA
        send_start();
        write_byte({7'h43, 1'b1}, a);
        chk("R1 mismatch read not acked", a, 0);
        v = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        chk("R1 mismatch read line idle", v, 8'hFF);
        send_stop();
        chk("R9 mismatch no pop", fhead, mhead);

        // R3: random read via repeated start
        set_ptr(8'h10, 1'b0);
        read_n(4, "R3 register byte");

        // R7: current address read continues
        read_n(2, "R7 continued byte");

        // R5 and R8: cross into stream, then run past its end
        set_ptr(8'hFD, 1'b0);
        read_n(5, "R8 boundary byte");
        chk("R5 saturated", reg_addr, 8'hFF);

        // R8: empty FIFO gives filler, no pop
        read_n(2, "R8 filler byte");

        // R9: pointer-only access pops nothing, R7 continues from it
        fcount = 7;
        set_ptr(8'h20, 1'b1);
        chk("R9 pointer-only no pop", fhead, mhead);
        set_ptr(8'hFF, 1'b1);
        chk("R9 pointer-only at stream no pop", fhead, mhead);
        set_ptr(8'h20, 1'b1);
        read_n(1, "R7 after pointer-only");

        // R10: repeated start cuts a pointer byte short
        send_start();
        write_byte({DEV, 1'b0}, a);
        chk("R10 address ack", a, 1);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        set_ptr(8'h30, 1'b0);
        read_n(2, "R10 byte after restart");

        // R3: sweep of pointer values
        for (int p = 0; p < 256; p += 8) begin
            set_ptr(8'(p), 1'b0);
            read_n(2, "R3 sweep byte");
        end
        set_ptr(8'hFE, 1'b0);
        read_n(3, "R5 sweep end byte");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule